// File: doc/BRIEF.md
# Bit-Programmable Parallel Port with Pattern Interrupt

This block is a parallel peripheral port whose pins can each be set as an input or an output. Software sets pin directions, writes output levels, and reads back what the port sees through a small register interface. Input pins pass through a synchronizer before any logic uses them.

In bit-control mode, the port can raise an interrupt when the pins form a programmed pattern. A mask register selects which pins take part in the test. One control bit chooses whether the active level is high or low. A second control bit chooses how the pins combine: AND means every selected pin must be active, OR means any one selected pin is enough.

The interrupt request is a level signal. It goes high when the match condition changes from false to true. It then stays high until software writes the acknowledge address. While the condition remains true, no new request is raised. In any other mode the pattern test is switched off.

Top module: `pport_top`

## Requirements
- R1: After reset, `pin_oe` and `pin_out` are all zero and `irq` is 0. The direction and mask registers read back as all ones, and the control register reads back as 0.
- R2: Address 0 holds the output data and address 1 holds the direction. A direction bit of 1 makes that pin an input (`pin_oe` bit 0). A direction bit of 0 makes it an output (`pin_oe` bit 1). `pin_out` always equals the output data register.
- R3: Reading address 0 returns, for each pin, the synchronized pin level if it is an input, or the output data bit if it is an output. Reading addresses 1, 2 and 3 returns the direction, mask and control registers.
- R4: A change on `pin_in` appears in the address-0 read value after exactly two rising clock edges.
- R5: Control bit 1 selects the combining function. When it is 0 (OR), the condition is true if any unmasked pin is at the active level.
- R6: When control bit 1 is 1 (AND), the condition is true only if every unmasked pin is at the active level.
- R7: Control bit 0 selects the active level. A value of 1 means active high and 0 means active low.
- R8: Address 2 is the mask. A mask bit of 1 removes that pin from the condition. With every pin masked, the condition is false in both AND and OR modes.
- R9: `irq` goes to 1 on the clock edge after the condition goes from false to true. It then stays at 1 until acknowledged. While the condition stays true after an acknowledge, `irq` is not raised again.
- R10: A write to address 4 (the acknowledge) clears `irq`. If a new false-to-true transition happens in the same cycle, the transition wins and `irq` stays 1.
- R11: Control bits 3:2 hold the mode, and the value 2'b11 selects bit-control mode. In any other mode the condition is forced false. Entering bit-control mode while the pattern already matches counts as a false-to-true transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data for `bus_addr` (combinational) |
| pin_in | input | WIDTH | Pin levels as seen from outside |
| pin_out | output | WIDTH | Pin output levels |
| pin_oe | output | WIDTH | Per-pin output enable |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the port with WIDTH set to 4. At that width, every combination of mask, pin pattern, active level and combining function can be swept, which is 1024 cases.

Each case starts with all pins masked, so the condition is false, and then writes the target mask. Because of this, every expected true result must show up as a fresh request one edge later. The all-masked corner appears in every mode.

Separate directed sequences cover:
- the two-edge synchronizer delay;
- the hold and no-retrigger behaviour;
- an acknowledge that collides with a new rise;
- turning off the pattern test outside bit-control mode.

// File: rtl/pport_pkg.sv
// Shared constants for the parallel port: register addresses and control
// field positions. Assumes the control register is at least 4 bits wide.
package pport_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] A_DIR  = 3'd1;
    localparam logic [ADDR_W-1:0] A_MASK = 3'd2;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd3;
    localparam logic [ADDR_W-1:0] A_ACK  = 3'd4;

    localparam int CTRL_W     = 4;
    localparam int CTL_LEVEL  = 0;
    localparam int CTL_AND    = 1;
    localparam int CTL_MODE   = 2;
    localparam logic [1:0] MODE_BIT = 2'b11;
endpackage

// File: rtl/pport_sync.sv
// Multi-stage synchronizer for the pin inputs.
// Assumes each pin is an independent level; no bus coherency across bits.
module pport_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            // one flop rank of the synchronizer chain
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage[i] <= '0;
                else if (i == 0)
                    stage[i] <= d;
                else
                    stage[i] <= stage[(i > 0) ? i - 1 : 0];
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/pport_regs.sv
// Register bank of the port: output data, direction, mask, control,
// plus the acknowledge strobe and the combinational read mux.
// Assumes WIDTH >= CTRL_W.
module pport_regs
    import pport_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [WIDTH-1:0]  pin_view,
    output logic [WIDTH-1:0]  rdata,
    output logic [WIDTH-1:0]  data_q,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  mask_q,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              ack_pulse
);
    // register writes from the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '1;
            mask_q <= '1;
            ctrl_q <= '0;
        end else if (we) begin
            case (addr)
                A_DATA:  data_q <= wdata;
                A_DIR:   dir_q  <= wdata;
                A_MASK:  mask_q <= wdata;
                A_CTRL:  ctrl_q <= wdata[CTRL_W-1:0];
                default: ;
            endcase
        end
    end

    // acknowledge is a write to its own address, no storage
    assign ack_pulse = we && (addr == A_ACK);

    // read mux
    always_comb begin
        case (addr)
            A_DATA:  rdata = pin_view;
            A_DIR:   rdata = dir_q;
            A_MASK:  rdata = mask_q;
            A_CTRL:  rdata = {{(WIDTH-CTRL_W){1'b0}}, ctrl_q};
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/pport_match.sv
// Pattern evaluator: combines the unmasked pins at the chosen active level
// with AND or OR. Purely combinational. All-masked gives false in both modes.
module pport_match #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] view,
    input  logic [WIDTH-1:0] mask,
    input  logic             active_high,
    input  logic             and_mode,
    input  logic             enable,
    output logic             hit
);
    logic [WIDTH-1:0] active;
    logic [WIDTH-1:0] incl;
    logic             any_hit;
    logic             all_hit;

    // evaluate per-pin activity and the two combining functions
    always_comb begin
        active  = active_high ? view : ~view;
        incl    = ~mask;
        any_hit = |(incl & active);
        all_hit = (|incl) && ((active & incl) == incl);
        hit     = enable && (and_mode ? all_hit : any_hit);
    end
endmodule

// File: rtl/pport_top.sv
// Parallel port top: pin direction, output drive, synchronized read view,
// and a pattern interrupt raised on a false-to-true edge of the match,
// held until a software acknowledge. Synchronous active-low reset.
module pport_top
    import pport_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    output logic              irq
);
    logic [WIDTH-1:0]  pin_s;
    logic [WIDTH-1:0]  pin_view;
    logic [WIDTH-1:0]  data_q;
    logic [WIDTH-1:0]  dir_q;
    logic [WIDTH-1:0]  mask_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              ack_pulse;
    logic              bitmode;
    logic              match_c;
    logic              match_q;
    logic              rise;
    logic              irq_q;

    pport_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
    );

    // inputs show the synchronized pin, outputs show the driven value
    assign pin_view = (dir_q & pin_s) | (~dir_q & data_q);

    pport_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .pin_view(pin_view), .rdata(bus_rdata),
        .data_q(data_q), .dir_q(dir_q), .mask_q(mask_q), .ctrl_q(ctrl_q),
        .ack_pulse(ack_pulse)
    );

    assign bitmode = (ctrl_q[CTL_MODE +: 2] == MODE_BIT);

    pport_match #(.WIDTH(WIDTH)) u_match (
        .view(pin_view), .mask(mask_q),
        .active_high(ctrl_q[CTL_LEVEL]), .and_mode(ctrl_q[CTL_AND]),
        .enable(bitmode), .hit(match_c)
    );

    assign rise = match_c && !match_q;

    // remember last condition and hold the request until acknowledged
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            match_q <= match_c;
            if (rise)
                irq_q <= 1'b1;
            else if (ack_pulse)
                irq_q <= 1'b0;
        end
    end

    assign pin_out = data_q;
    assign pin_oe  = ~dir_q;
    assign irq     = irq_q;
endmodule

// File: rtl/pport_checker.sv
// Property checker for pport_top, attached by bind. Observes internal
// condition and register state alongside the ports.
module pport_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack_wr,
    input logic             dir_wr,
    input logic [WIDTH-1:0] wdata,
    input logic [WIDTH-1:0] pin_oe,
    input logic [WIDTH-1:0] mask_q,
    input logic             bitmode,
    input logic             match_c,
    input logic             match_q,
    input logic             irq
);
    p_oe_follows_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dir_wr |=> (pin_oe == ~$past(wdata)));

    p_all_masked_false_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |-> !match_c);

    p_rise_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (match_c && !match_q) |=> irq);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack_wr) |=> irq);

    p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !(match_c && !match_q)) |=> !irq);

    p_mode_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bitmode |-> !match_c);
endmodule

bind pport_top pport_checker #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .ack_wr(ack_pulse),
    .dir_wr(bus_we && (bus_addr == pport_pkg::A_DIR)),
    .wdata(bus_wdata), .pin_oe(pin_oe), .mask_q(mask_q),
    .bitmode(bitmode), .match_c(match_c), .match_q(match_q), .irq(irq)
);

// File: tb/tb_pport_top.sv
module tb_pport_top;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_we = 1'b0;
    logic [2:0]   bus_addr = '0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] pin_in = '0;
    logic [W-1:0] pin_out;
    logic [W-1:0] pin_oe;
    logic         irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pport_top #(.WIDTH(W), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic waitn(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic bit expect_hit(input int m, input int p, input bit hi, input bit an);
        int act;
        int inc;
        act = hi ? p : (~p & 15);
        inc = ~m & 15;
        if (an) return (inc != 0) && ((act & inc) == inc);
        return (inc & act) != 0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v;
        waitn(3);
        rst_n = 1'b1;
        waitn(1);

        // R1 reset state
        chk("R1 pin_oe", int'(pin_oe), 0);
        chk("R1 pin_out", int'(pin_out), 0);
        chk("R1 irq", int'(irq), 0);
        rd(3'd1, v); chk("R1 dir", v, 15);
        rd(3'd2, v); chk("R1 mask", v, 15);
        rd(3'd3, v); chk("R1 ctrl", v, 0);

        // R2 / R3 direction, drive and mixed read view
        wr(3'd0, 4'b1010);
        wr(3'd1, 4'b0011);
        chk("R2 pin_oe", int'(pin_oe), 4'b1100);
        chk("R2 pin_out", int'(pin_out), 4'b1010);
        pin_in = 4'b0101;
        waitn(3);
        rd(3'd0, v); chk("R3 mixed view", v, 4'b1001);
        rd(3'd1, v); chk("R3 dir readback", v, 4'b0011);
        wr(3'd2, 4'b0110);
        rd(3'd2, v); chk("R3 mask readback", v, 4'b0110);

        // R4 / R9 synchronizer latency and interrupt timing
        wr(3'd1, 4'b1111);
        pin_in = 4'b0000;
        wr(3'd2, 4'b1110);
        wr(3'd3, 4'b1101);          // bit mode, OR, active high
        waitn(3);
        wr(3'd4, '0);
        chk("R9 idle irq", int'(irq), 0);
        pin_in = 4'b0001;
        waitn(1);
        rd(3'd0, v); chk("R4 one edge", v, 0);
        waitn(1);
        rd(3'd0, v); chk("R4 two edges", v, 1);
        chk("R9 not yet", int'(irq), 0);
        waitn(1);
        chk("R9 rise sets", int'(irq), 1);

        // R9 hold, R10 ack, no retrigger
        waitn(5);
        chk("R9 held", int'(irq), 1);
        wr(3'd4, '0);
        chk("R10 ack clears", int'(irq), 0);
        waitn(5);
        chk("R9 no retrigger", int'(irq), 0);

        // R10 rise in the ack cycle wins: pending irq, pin low then high
        pin_in = 4'b0000;
        waitn(3);
        pin_in = 4'b0001;
        waitn(3);
        chk("R10 setup pending", int'(irq), 1);
        pin_in = 4'b0000;
        waitn(3);
        pin_in = 4'b0001;
        waitn(2);
        bus_we = 1'b1; bus_addr = 3'd4;
        @(negedge clk);
        bus_we = 1'b0;
        chk("R10 rise beats ack", int'(irq), 1);
        wr(3'd4, '0);

        // R11 other mode disables
        pin_in = 4'b0000;
        wr(3'd3, 4'b0001);          // mode 00, OR, active high
        waitn(3);
        wr(3'd4, '0);
        pin_in = 4'b0001;
        waitn(5);
        chk("R11 off in other mode", int'(irq), 0);
        wr(3'd3, 4'b1001);          // mode 10
        waitn(2);
        chk("R11 off in mode 10", int'(irq), 0);
        wr(3'd3, 4'b1101);
        waitn(1);
        chk("R11 entering bit mode", int'(irq), 1);
        wr(3'd4, '0);

        // R5 R6 R7 R8 exhaustive sweep
        for (int md = 0; md < 4; md++) begin
            wr(3'd2, 4'hF);
            wr(3'd3, {2'b11, md[1], md[0]});
            for (int m = 0; m < 16; m++) begin
                for (int p = 0; p < 16; p++) begin
                    bit e;
                    e = expect_hit(m, p, md[0], md[1]);
                    wr(3'd2, 4'hF);
                    pin_in = p[W-1:0];
                    waitn(2);
                    wr(3'd4, '0);
                    chk("R8 all masked quiet", int'(irq), 0);
                    wr(3'd2, m[W-1:0]);
                    waitn(1);
                    if (md[1])
                        chk($sformatf("R6 R7 R8 and m=%0d p=%0d lvl=%0d", m, p, md[0]), int'(irq), int'(e));
                    else
                        chk($sformatf("R5 R7 R8 or m=%0d p=%0d lvl=%0d", m, p, md[0]), int'(irq), int'(e));
                end
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule